// File: doc/BRIEF.md
# Sample-Rate Classifier with Hysteresis

This block takes a frame-sync strobe from an audio receiver and times it against a fixed reference clock. It counts reference cycles between consecutive strobes and decides two things. First, whether the stream is in the high-rate (96 kHz) class or the normal-rate class, with a wide dead band between the two decisions. Second, whether the frame timing is usable at all. A stream is usable when its rate lies between 22 kHz and 108 kHz.

Every threshold is a cycle count. Each one is computed at elaboration from the reference frequency parameter.

When the receiver runs from its local oscillator, the high-rate output no longer shows the measurement. It shows a rate bit that software sets. Measurement and lock tracking continue in the background.

Top module: `rate_classifier`

## Requirements
- R1: While reset is asserted and right after it, `unlock` is 1 and the measured rate class is normal (`hi_rate` = 0 with `osc_mode` = 0).
- R2: A period is the number of reference cycles between two consecutive sampled strobes. The first strobe after reset only starts timing and produces no period.
- R3: `unlock` falls in the cycle after the LOCK_RUN-th consecutive in-range period (default 4), and not earlier. A period is in range when it lies between ceil(REF_HZ/108000) and floor(REF_HZ/22000) cycles inclusive.
- R4: A period outside that range sets `unlock` to 1 in the next cycle and restarts the consecutive count.
- R5: If no strobe arrives for floor(REF_HZ/22000)+1 cycles after the last one, `unlock` goes to 1 on that cycle's edge.
- R6: An in-range period of at most floor(REF_HZ/88200) cycles sets the measured class to high-rate.
- R7: An in-range period of at least ceil(REF_HZ/54000) cycles sets the measured class to normal-rate.
- R8: An in-range period strictly between those two limits leaves the measured class unchanged.
- R9: Out-of-range periods and timeouts leave the measured class unchanged.
- R10: With `osc_mode` = 1, `hi_rate` equals `osc_hi_bit` in the same cycle. With `osc_mode` = 0, it shows the measured class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fixed-frequency reference clock (REF_HZ) |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_strobe | input | 1 | One-cycle pulse per received frame |
| osc_mode | input | 1 | 1 = local oscillator is the clock source |
| osc_hi_bit | input | 1 | Software rate bit used in oscillator mode |
| hi_rate | output | 1 | High-rate class flag |
| unlock | output | 1 | 1 when frame timing is not trusted |

## Verification
The assertions assume that `fs_strobe` is a clean pulse synchronous to `clk`. They also assume that a strobe lasting several cycles means several frames, since every sampled high cycle is taken as a frame edge. The bench therefore drives each strobe high for exactly one cycle, away from the sampling edge. It spaces strobes by chosen integer cycle counts and runs the block with a small reference frequency, so that every threshold falls on short, exact periods. The assertions also assume that `osc_mode` and `osc_hi_bit` are stable levels. The bench changes them only between strobes.

// File: rtl/rate_pkg.sv
package rate_pkg;
  // All limits are cycle counts of the reference clock per frame.
  function automatic longint unsigned up_div(longint unsigned num, longint unsigned den);
    return (num + den - 1) / den;
  endfunction

  // shortest legal frame: fastest supported rate, 108 kHz
  function automatic int min_period(longint unsigned ref_hz);
    return int'(up_div(ref_hz, 64'd108000));
  endfunction

  // longest legal frame: slowest supported rate, 22 kHz
  function automatic int max_period(longint unsigned ref_hz);
    return int'(ref_hz / 64'd22000);
  endfunction

  // period at or below this means rate >= 88.2 kHz
  function automatic int hi_limit(longint unsigned ref_hz);
    return int'((ref_hz * 64'd10) / 64'd882000);
  endfunction

  // period at or above this means rate <= 54 kHz
  function automatic int lo_limit(longint unsigned ref_hz);
    return int'(up_div(ref_hz, 64'd54000));
  endfunction
endpackage

// File: rtl/period_meter.sv
module period_meter #(
  parameter int CW  = 12,
  parameter int TMO = 1118
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  output logic          per_vld,
  output logic [CW-1:0] per_val,
  output logic          tmo
);
  localparam logic [CW-1:0] TMO_C = CW'(TMO);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (strobe) armed <= 1'b1;
      if (strobe)              cnt <= CW'(1);
      else if (cnt != TMO_C)   cnt <= cnt + CW'(1);
    end
  end

  assign per_vld = strobe & armed;
  assign per_val = cnt;
  assign tmo     = (cnt == TMO_C);
endmodule

// File: rtl/lock_tracker.sv
module lock_tracker #(
  parameter int CW       = 12,
  parameter int PMIN     = 228,
  parameter int PMAX     = 1117,
  parameter int LOCK_RUN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          per_vld,
  input  logic [CW-1:0] per_val,
  input  logic          tmo,
  output logic          good,
  output logic          unlock
);
  localparam int RW = $clog2(LOCK_RUN + 1);
  localparam logic [RW-1:0] LAST = RW'(LOCK_RUN - 1);
  localparam logic [CW-1:0] LO_C = CW'(PMIN);
  localparam logic [CW-1:0] HI_C = CW'(PMAX);

  logic [RW-1:0] run;
  logic          bad;

  assign good = per_vld && (per_val >= LO_C) && (per_val <= HI_C);
  assign bad  = tmo || (per_vld && !good);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= '0;
      unlock <= 1'b1;
    end else if (bad) begin
      run    <= '0;
      unlock <= 1'b1;
    end else if (good) begin
      if (run < LAST) run <= run + RW'(1);
      else            unlock <= 1'b0;
    end
  end
endmodule

// File: rtl/rate_decider.sv
module rate_decider #(
  parameter int CW     = 12,
  parameter int HI_MAX = 278,
  parameter int LO_MIN = 456
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          good,
  input  logic [CW-1:0] per_val,
  output logic          meas_hi
);
  localparam logic [CW-1:0] HI_C = CW'(HI_MAX);
  localparam logic [CW-1:0] LO_C = CW'(LO_MIN);

  always_ff @(posedge clk) begin
    if (!rst_n)                        meas_hi <= 1'b0;
    else if (good && per_val <= HI_C)  meas_hi <= 1'b1;
    else if (good && per_val >= LO_C)  meas_hi <= 1'b0;
  end
endmodule

// File: rtl/rate_classifier.sv
module rate_classifier #(
  parameter longint unsigned REF_HZ   = 64'd24576000,
  parameter int              LOCK_RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_strobe,
  input  logic osc_mode,
  input  logic osc_hi_bit,
  output logic hi_rate,
  output logic unlock
);
  localparam int PMIN   = rate_pkg::min_period(REF_HZ);
  localparam int PMAX   = rate_pkg::max_period(REF_HZ);
  localparam int HI_MAX = rate_pkg::hi_limit(REF_HZ);
  localparam int LO_MIN = rate_pkg::lo_limit(REF_HZ);
  localparam int TMO    = PMAX + 1;
  localparam int CW     = $clog2(PMAX + 2);

  logic          p_vld;
  logic [CW-1:0] p_val;
  logic          tmo;
  logic          good;
  logic          meas_hi;

  period_meter #(.CW(CW), .TMO(TMO)) u_meter (
    .clk(clk), .rst_n(rst_n), .strobe(fs_strobe),
    .per_vld(p_vld), .per_val(p_val), .tmo(tmo)
  );

  lock_tracker #(.CW(CW), .PMIN(PMIN), .PMAX(PMAX), .LOCK_RUN(LOCK_RUN)) u_lock (
    .clk(clk), .rst_n(rst_n), .per_vld(p_vld), .per_val(p_val), .tmo(tmo),
    .good(good), .unlock(unlock)
  );

  rate_decider #(.CW(CW), .HI_MAX(HI_MAX), .LO_MIN(LO_MIN)) u_dec (
    .clk(clk), .rst_n(rst_n), .good(good), .per_val(p_val), .meas_hi(meas_hi)
  );

  assign hi_rate = osc_mode ? osc_hi_bit : meas_hi;
endmodule

// File: rtl/rate_classifier_chk.sv
module rate_classifier_chk #(
  parameter int CW     = 12,
  parameter int PMIN   = 228,
  parameter int PMAX   = 1117,
  parameter int HI_MAX = 278,
  parameter int LO_MIN = 456
) (
  input logic          clk,
  input logic          rst_n,
  input logic          p_vld,
  input logic [CW-1:0] p_val,
  input logic          tmo,
  input logic          meas_hi,
  input logic          unlock,
  input logic          osc_mode,
  input logic          osc_hi_bit,
  input logic          hi_rate
);
  logic in_rng;
  assign in_rng = p_vld && (int'(p_val) >= PMIN) && (int'(p_val) <= PMAX);

  AST_RESET_UNLOCKED: assert property (@(posedge clk) !rst_n |=> unlock); // R1
  AST_LOCK_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unlock) |-> $past(in_rng)); // R3
  AST_BAD_PERIOD_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (p_vld && !in_rng) |=> unlock); // R4
  AST_TIMEOUT_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> unlock); // R5
  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rng && int'(p_val) <= HI_MAX) |=> meas_hi); // R6
  AST_FALL_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rng && int'(p_val) >= LO_MIN) |=> !meas_hi); // R7
  AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rng && int'(p_val) > HI_MAX && int'(p_val) < LO_MIN) |=> $stable(meas_hi)); // R8
  AST_NO_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_rng |=> $stable(meas_hi)); // R9
  AST_OSC_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    osc_mode |-> (hi_rate == osc_hi_bit)); // R10
endmodule

bind rate_classifier rate_classifier_chk #(
  .CW(CW), .PMIN(PMIN), .PMAX(PMAX), .HI_MAX(HI_MAX), .LO_MIN(LO_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .p_vld(p_vld), .p_val(p_val), .tmo(tmo),
  .meas_hi(meas_hi), .unlock(unlock), .osc_mode(osc_mode),
  .osc_hi_bit(osc_hi_bit), .hi_rate(hi_rate)
);

// File: tb/test_rate_classifier.sv
`timescale 1ns/1ps
module test_rate_classifier;
  localparam longint unsigned REF = 64'd2000000;
  localparam int RUN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_strobe = 1'b0;
  logic osc_mode = 1'b0;
  logic osc_hi_bit = 1'b0;
  logic hi_rate;
  logic unlock;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // limits restated from the requirements with real arithmetic
  int p_lo, p_hi, hi_edge, lo_edge;

  always #2 clk = ~clk;

  rate_classifier #(.REF_HZ(REF), .LOCK_RUN(RUN)) i_rate_classifier (
    .clk(clk), .rst_n(rst_n), .fs_strobe(fs_strobe), .osc_mode(osc_mode),
    .osc_hi_bit(osc_hi_bit), .hi_rate(hi_rate), .unlock(unlock)
  );

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // strobe n cycles after the previous one; returns on the negedge after it is sampled
  task automatic frame_after(int n);
    repeat (n - 1) @(negedge clk);
    fs_strobe = 1'b1;
    @(negedge clk);
    fs_strobe = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fs_strobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 unlock in reset", unlock, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 unlock after reset", unlock, 1'b1);
    check("R1 rate after reset", hi_rate, 1'b0);
  endtask

  task automatic t_lock(int per);
    frame_after(1);                       // R2: arming strobe, no period
    check("R2 arm only", unlock, 1'b1);
    for (int i = 0; i < RUN - 1; i++) frame_after(per);
    check("R3 not yet locked", unlock, 1'b1);
    frame_after(per);
    check("R3 locked", unlock, 1'b0);
  endtask

  task automatic t_range();
    frame_after(p_lo - 1);
    check("R4 short period unlocks", unlock, 1'b1);
    for (int i = 0; i < RUN; i++) frame_after(p_lo);
    check("R3 lock at shortest legal period", unlock, 1'b0);
    for (int i = 0; i < RUN; i++) frame_after(p_hi);
    check("R3 stays locked at longest legal period", unlock, 1'b0);
    for (int i = 0; i < RUN - 1; i++) frame_after(40);
    frame_after(p_lo - 1);
    for (int i = 0; i < RUN - 1; i++) frame_after(40);
    check("R4 count restarted after bad period", unlock, 1'b1);
    frame_after(40);
    check("R4 relock after full run", unlock, 1'b0);
  endtask

  task automatic t_timeout();
    repeat (p_hi) @(negedge clk);
    check("R5 no timeout at last legal cycle", unlock, 1'b0);
    @(negedge clk);
    check("R5 timeout unlocks", unlock, 1'b1);
    repeat (20) @(negedge clk);
    frame_after(1);
    for (int i = 0; i < RUN; i++) frame_after(40);
    check("R5 relock after timeout", unlock, 1'b0);
  endtask

  task automatic t_class();
    frame_after(hi_edge + 1);
    check("R8 above high limit keeps normal", hi_rate, 1'b0);
    frame_after(hi_edge);
    check("R6 rise at high limit", hi_rate, 1'b1);
    frame_after(30);
    check("R8 band holds high", hi_rate, 1'b1);
    frame_after(lo_edge - 1);
    check("R8 just under low limit holds high", hi_rate, 1'b1);
    frame_after(lo_edge);
    check("R7 fall at low limit", hi_rate, 1'b0);
    frame_after(p_lo);
    check("R6 rise at shortest legal period", hi_rate, 1'b1);
    frame_after(p_hi);
    check("R7 fall at longest legal period", hi_rate, 1'b0);
    frame_after(hi_edge);
    check("R6 rise again", hi_rate, 1'b1);
    frame_after(p_lo - 1);
    check("R9 too-short period leaves class", hi_rate, 1'b1);
    check("R4 too-short period unlocks", unlock, 1'b1);
    repeat (p_hi + 10) @(negedge clk);
    check("R9 timeout leaves class", hi_rate, 1'b1);
    frame_after(1);
    check("R9 late strobe leaves class", hi_rate, 1'b1);
  endtask

  task automatic t_osc();
    osc_mode = 1'b1;
    osc_hi_bit = 1'b0;
    #1;
    check("R10 osc bit 0 overrides", hi_rate, 1'b0);
    osc_hi_bit = 1'b1;
    #1;
    check("R10 osc bit 1", hi_rate, 1'b1);
    @(negedge clk);
    osc_hi_bit = 1'b0;
    frame_after(hi_edge);
    frame_after(hi_edge);
    check("R10 measurement hidden in osc mode", hi_rate, 1'b0);
    osc_mode = 1'b0;
    #1;
    check("R10 measured class back", hi_rate, 1'b1);
    @(negedge clk);
  endtask

  initial begin
    p_lo    = int'($ceil(real'(REF) / 108000.0));
    p_hi    = int'($floor(real'(REF) / 22000.0));
    hi_edge = int'($floor(real'(REF) / 88200.0));
    lo_edge = int'($ceil(real'(REF) / 54000.0));
    do_reset();
    t_lock(42);
    t_range();
    t_timeout();
    t_class();
    t_osc();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule